// File: doc/BRIEF.md
# Coprocessor Command Dispatch Hub

The hub lets a host start a run on a coprocessor and learn when the run has finished. The host writes a command block: a start address, a set of scalar parameters and a sequence number. The host writes the sequence number last. The hub treats a sequence number that differs from the last one it consumed as a new command. It then copies the parameters into its scalar registers and fetches instructions one word at a time, starting at the start address, through a simple memory read port.

Each fetched word is classified by its opcode. Base opcodes run inside the hub on a small scalar stub. Extended opcodes are sent on a command bus, with the opcode and two scalar operands, to all four engine ports at once. A halt, or an undefined base opcode, ends the run. The hub then writes a status block with a completion flag, the sequence number of the run and an error code. The host polls the status block.

Top module: `cmd_dispatch_hub`

## Requirements
- R1: After reset, `mr_req`, `cb_valid`, `st_done` and `st_err` are all 0, and nothing is fetched until a command arrives.
- R2: A run starts only when the sequence field (host index 0, data bits [7:0]) differs from the last value consumed. Writes to the start address (index 1) or to the parameters (indices 2 to 5), and a write of an unchanged sequence value, start nothing.
- R3: Fetches begin at the start address and step by one word per instruction. Each request holds `mr_req` high with a stable `mr_addr` until `mr_valid` returns the word.
- R4: An opcode (bits [31:24]) with bit 7 clear runs locally and never drives `cb_valid`. 8'h01 does nothing. 8'h02 loads the zero-extended immediate in bits [17:0] into the scalar register selected by bits [23:22]. 8'h03 adds that immediate to the selected register.
- R5: An opcode with bit 7 set is broadcast: `cb_op` carries the opcode, `cb_a` the scalar register selected by bits [21:20], and `cb_b` the register selected by bits [19:18]. At run start, scalar register i is loaded with parameter i (host index 2+i), and its value is passed through uninterpreted.
- R6: `cb_valid` is high only in a cycle where all four `eng_ready` bits are high. While any engine is not ready, the broadcast waits.
- R7: After a broadcast, no fetch is issued until every engine has pulsed `eng_ack`. The pulses may come in any order and in different cycles.
- R8: Opcode 8'h00 (halt) ends the run and sets `st_done`=1, `st_seq` to the run's sequence number and `st_err`=0. The status holds until the next run ends.
- R9: An undefined base opcode (8'h04 to 8'h7F) sets `st_err`=1 and ends the run. No further word is fetched.
- R10: A new sequence number written during a run is held pending. It starts only after the current run's status is written. The current run keeps the parameters it started with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hw_en | input | 1 | Host write strobe into the command block |
| hw_idx | input | 3 | Field index: 0 sequence, 1 start address, 2..5 parameters |
| hw_data | input | 32 | Host write data |
| mr_req | output | 1 | Instruction fetch request |
| mr_addr | output | 16 | Fetch word address |
| mr_valid | input | 1 | Fetch data returned |
| mr_data | input | 32 | Fetched instruction word |
| eng_ready | input | 4 | Per-engine ready |
| eng_ack | input | 4 | Per-engine completion pulse |
| cb_valid | output | 1 | Broadcast strobe to all engines |
| cb_op | output | 8 | Broadcast opcode |
| cb_a | output | 32 | First scalar operand |
| cb_b | output | 32 | Second scalar operand |
| st_done | output | 1 | Status: a run has completed |
| st_seq | output | 8 | Status: sequence number of the completed run |
| st_err | output | 2 | Status: 0 normal halt, 1 undefined opcode |

## Verification
The bench builds the hub with its default parameters: 16-bit addresses, 32-bit data, an 8-bit sequence number, four parameters and four engines. Four scalar registers make every 2-bit register select reachable. Random sequence increments of up to 20 over thirty runs carry the 8-bit sequence number past its wrap. Random engine ready and acknowledge timing, and memory latency, exercise the broadcast waits and the ordering of fetch after acknowledge.

// File: rtl/cmd_dispatch_hub.sv
`timescale 1ns/1ps
module cmd_dispatch_hub #(
  parameter int AW     = 16,
  parameter int DW     = 32,
  parameter int IW     = 32,
  parameter int SEQW   = 8,
  parameter int NPARAM = 4,
  parameter int NENG   = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              hw_en,
  input  logic [$clog2(NPARAM+2)-1:0]       hw_idx,
  input  logic [DW-1:0]                     hw_data,
  output logic                              mr_req,
  output logic [AW-1:0]                     mr_addr,
  input  logic                              mr_valid,
  input  logic [IW-1:0]                     mr_data,
  input  logic [NENG-1:0]                   eng_ready,
  input  logic [NENG-1:0]                   eng_ack,
  output logic                              cb_valid,
  output logic [7:0]                        cb_op,
  output logic [DW-1:0]                     cb_a,
  output logic [DW-1:0]                     cb_b,
  output logic                              st_done,
  output logic [SEQW-1:0]                   st_seq,
  output logic [1:0]                        st_err
);
  localparam int IDXW = $clog2(NPARAM+2);
  localparam int RSW  = $clog2(NPARAM);
  localparam int IMMW = IW - 8 - 3*RSW;
  localparam logic [NENG-1:0] ALL = {NENG{1'b1}};

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_DEC, S_ISSUE, S_ACK} st_t;
  st_t state;

  logic [SEQW-1:0] cmd_seq, last_seq, run_seq;
  logic [AW-1:0]   cmd_addr, pc;
  logic [DW-1:0]   cmd_par [NPARAM];
  logic [DW-1:0]   sreg    [NPARAM];
  logic [IW-1:0]   ir;
  logic [NENG-1:0] ack_seen;

  wire [7:0]      op      = ir[IW-1 -: 8];
  wire [RSW-1:0]  rd      = ir[IW-9 -: RSW];
  wire [RSW-1:0]  ra      = ir[IW-9-RSW -: RSW];
  wire [RSW-1:0]  rb      = ir[IW-9-2*RSW -: RSW];
  wire [DW-1:0]   imm     = DW'(ir[IMMW-1:0]);
  wire            pending = cmd_seq != last_seq;
  wire [NENG-1:0] ack_all = ack_seen | eng_ack;

  assign mr_req   = state == S_FETCH;
  assign mr_addr  = pc;
  assign cb_valid = (state == S_ISSUE) && (&eng_ready);
  assign cb_op    = op;
  assign cb_a     = sreg[ra];
  assign cb_b     = sreg[rb];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_seq  <= '0;
      cmd_addr <= '0;
      for (int i = 0; i < NPARAM; i++) cmd_par[i] <= '0;
    end else if (hw_en) begin
      if (hw_idx == IDXW'(0)) cmd_seq  <= hw_data[SEQW-1:0];
      if (hw_idx == IDXW'(1)) cmd_addr <= hw_data[AW-1:0];
      for (int i = 0; i < NPARAM; i++)
        if (hw_idx == IDXW'(i+2)) cmd_par[i] <= hw_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      last_seq <= '0;
      run_seq  <= '0;
      pc       <= '0;
      ir       <= '0;
      ack_seen <= '0;
      st_done  <= 1'b0;
      st_seq   <= '0;
      st_err   <= 2'd0;
      for (int i = 0; i < NPARAM; i++) sreg[i] <= '0;
    end else begin
      case (state)
        S_IDLE: if (pending) begin
          last_seq <= cmd_seq;
          run_seq  <= cmd_seq;
          pc       <= cmd_addr;
          for (int i = 0; i < NPARAM; i++) sreg[i] <= cmd_par[i];
          state    <= S_FETCH;
        end
        S_FETCH: if (mr_valid) begin
          ir    <= mr_data;
          pc    <= pc + AW'(1);
          state <= S_DEC;
        end
        S_DEC: begin
          if (op[7]) state <= S_ISSUE;
          else begin
            case (op)
              8'h00: begin
                st_done <= 1'b1; st_seq <= run_seq; st_err <= 2'd0; state <= S_IDLE;
              end
              8'h01: state <= S_FETCH;
              8'h02: begin sreg[rd] <= imm; state <= S_FETCH; end
              8'h03: begin sreg[rd] <= sreg[rd] + imm; state <= S_FETCH; end
              default: begin
                st_done <= 1'b1; st_seq <= run_seq; st_err <= 2'd1; state <= S_IDLE;
              end
            endcase
          end
        end
        S_ISSUE: if (&eng_ready) begin
          ack_seen <= '0;
          state    <= S_ACK;
        end
        S_ACK: begin
          ack_seen <= ack_all;
          if (ack_all == ALL) state <= S_FETCH;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_SEQ_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && pending) |=> (mr_req && mr_addr == $past(cmd_addr))); // R2
  AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mr_req && !mr_valid) |=> (mr_req && $stable(mr_addr))); // R3
  AST_BASE_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    (mr_req && mr_valid && !mr_data[IW-1]) |=> !cb_valid); // R4
  AST_NO_FETCH_AFTER_BCAST: assert property (@(posedge clk) disable iff (!rst_n)
    cb_valid |=> !mr_req); // R7
  AST_ACK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ACK && ack_all != ALL) |=> !mr_req); // R7
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    st_done |=> st_done); // R8
  AST_UNDEF_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DEC && !op[7] && op > 8'h03) |=> (st_done && st_err == 2'd1 && !mr_req)); // R9
endmodule

// File: tb/tb_cmd_dispatch_hub.sv
`timescale 1ns/1ps
module tb_cmd_dispatch_hub;
  localparam int AW = 16, DW = 32, IW = 32, SEQW = 8, NP = 4, NE = 4;

  logic clk = 0, rst_n = 0;
  logic hw_en = 0; logic [2:0] hw_idx = 0; logic [DW-1:0] hw_data = 0;
  logic mr_req; logic [AW-1:0] mr_addr; logic mr_valid = 0; logic [IW-1:0] mr_data = 0;
  logic [NE-1:0] eng_ready = 0, eng_ack = 0;
  logic cb_valid; logic [7:0] cb_op; logic [DW-1:0] cb_a, cb_b;
  logic st_done; logic [SEQW-1:0] st_seq; logic [1:0] st_err;

  cmd_dispatch_hub dut (.*);

  always #10 clk = ~clk;

  logic [IW-1:0] mem [0:255];
  int nvec = 0, nbad = 0, cyc = 0;
  logic [AW-1:0] q_fetch[$];
  logic [7:0]    q_op[$];
  logic [DW-1:0] q_a[$], q_b[$];
  logic [NE-1:0] force_low = 0, pend = 0;
  int ack_cnt [NE];
  bit mbusy = 0, prev_req = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (!ok) begin nbad++; $display("FAIL %s act=%0h exp=%0h", tag, act, exp); end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin nbad++; $display("FAIL watchdog act=%0d exp=0", cyc); summary(); end
  end

  // memory stub
  always begin
    @(negedge clk);
    if (rst_n && mr_req && !mbusy) begin
      automatic logic [AW-1:0] a = mr_addr;
      automatic int lat = $urandom_range(0, 2);
      mbusy = 1;
      repeat (lat) @(posedge clk);
      @(posedge clk); #1 mr_data = mem[a[7:0]]; mr_valid = 1;
      @(posedge clk); #1 mr_valid = 0; mbusy = 0;
    end
  end

  // engine stubs
  initial for (int i = 0; i < NE; i++) ack_cnt[i] = 0;
  always @(posedge clk) begin
    #1;
    for (int i = 0; i < NE; i++) begin
      eng_ack[i] = 0;
      if (ack_cnt[i] > 0) begin ack_cnt[i]--; if (ack_cnt[i] == 0) eng_ack[i] = 1; end
      eng_ready[i] = rst_n && !force_low[i] && ($urandom % 4 != 0);
    end
  end

  // monitor
  always @(negedge clk) if (rst_n) begin
    for (int i = 0; i < NE; i++) if (eng_ack[i]) pend[i] = 0;
    if (mr_req && !prev_req) begin
      chk(pend == 0, "R7 fetch while acks outstanding", pend, 0);
      if (q_fetch.size() == 0) chk(0, "R3/R9 unexpected fetch", mr_addr, 0);
      else begin
        automatic logic [AW-1:0] e = q_fetch.pop_front();
        chk(mr_addr == e, "R3 fetch address", mr_addr, e);
      end
    end
    prev_req = mr_req;
    if (cb_valid) begin
      chk(&eng_ready, "R6 broadcast without all ready", eng_ready, 4'hf);
      if (q_op.size() == 0) chk(0, "R4 unexpected broadcast", cb_op, 0);
      else begin
        automatic logic [7:0] eo = q_op.pop_front();
        automatic logic [DW-1:0] ea = q_a.pop_front();
        automatic logic [DW-1:0] eb = q_b.pop_front();
        chk(cb_op == eo, "R5 cb_op", cb_op, eo);
        chk(cb_a == ea, "R5 cb_a", cb_a, ea);
        chk(cb_b == eb, "R5 cb_b", cb_b, eb);
      end
      for (int i = 0; i < NE; i++) ack_cnt[i] = $urandom_range(1, 4);
      pend = '1;
    end
  end

  function automatic logic [IW-1:0] ins(input logic [7:0] op, input int d, input int a, input int b, input logic [17:0] imm);
    return {op, 2'(d), 2'(a), 2'(b), imm};
  endfunction

  task automatic model(input logic [AW-1:0] start, input logic [NP-1:0][DW-1:0] p, output logic [1:0] err);
    logic [NP-1:0][DW-1:0] s = p;
    logic [AW-1:0] pc = start;
    err = 2'd3;
    for (int k = 0; k < 64; k++) begin
      automatic logic [IW-1:0] w = mem[pc[7:0]];
      automatic logic [7:0] op = w[31:24];
      automatic logic [DW-1:0] im = {14'b0, w[17:0]};
      q_fetch.push_back(pc); pc++;
      if (op[7]) begin q_op.push_back(op); q_a.push_back(s[w[21:20]]); q_b.push_back(s[w[19:18]]); end
      else if (op == 8'h00) begin err = 0; return; end
      else if (op == 8'h01) ;
      else if (op == 8'h02) s[w[23:22]] = im;
      else if (op == 8'h03) s[w[23:22]] = s[w[23:22]] + im;
      else begin err = 1; return; end
    end
  endtask

  task automatic hw_wr(input int idx, input logic [DW-1:0] d);
    @(posedge clk); #1 hw_en = 1; hw_idx = 3'(idx); hw_data = d;
    @(posedge clk); #1 hw_en = 0;
  endtask

  task automatic launch(input logic [AW-1:0] start, input logic [NP-1:0][DW-1:0] p, input logic [SEQW-1:0] seq, output logic [1:0] err);
    for (int i = 0; i < NP; i++) hw_wr(i + 2, p[i]);
    hw_wr(1, DW'(start));
    model(start, p, err);
    hw_wr(0, DW'(seq));
  endtask

  task automatic wait_done(input logic [SEQW-1:0] seq, input logic [1:0] eerr, input string tag);
    int t = 0;
    do begin @(negedge clk); t++; end while (!(st_done && st_seq == seq) && t < 3000);
    chk(st_done && st_seq == seq, {tag, " R8 status seq"}, st_seq, seq);
    chk(st_err == eerr, {tag, " R8/R9 error code"}, st_err, eerr);
    chk(q_fetch.size() == 0 && q_op.size() == 0, {tag, " R4/R5 pending expectations"}, q_fetch.size() + q_op.size(), 0);
  endtask

  task automatic gen_prog(input int start, input int len, input bit undef);
    int up = undef ? $urandom_range(0, len - 1) : -1;
    for (int k = 0; k < len; k++) begin
      automatic int r = $urandom % 10;
      automatic logic [7:0] op = (r < 4) ? 8'h80 | 8'($urandom % 128) : (r < 5) ? 8'h01 : (r < 7) ? 8'h02 : 8'h03;
      if (k == up) op = 8'(4 + $urandom % 124);
      mem[start + k] = ins(op, $urandom % 4, $urandom % 4, $urandom % 4, 18'($urandom));
    end
    mem[start + len] = ins(8'h00, 0, 0, 0, 0);
  endtask

  initial begin
    logic [1:0] e, eb;
    logic [NP-1:0][DW-1:0] p;
    logic [SEQW-1:0] seq;
    bit bad;
    int t;
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 256; i++) mem[i] = 0;
    repeat (3) @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    chk(st_done == 0, "R1 st_done after reset", st_done, 0);
    chk(st_err == 0, "R1 st_err after reset", st_err, 0);
    chk(mr_req == 0, "R1 mr_req after reset", mr_req, 0);
    chk(cb_valid == 0, "R1 cb_valid after reset", cb_valid, 0);

    // R2: writes without a sequence change start nothing
    hw_wr(2, 32'hdead); hw_wr(1, 32'h10); hw_wr(0, 32'h0);
    bad = 0;
    repeat (20) begin @(negedge clk); if (mr_req) bad = 1; end
    chk(!bad, "R2 no run on unchanged sequence", bad, 0);

    // R8: halt only
    mem[16] = ins(8'h00, 0, 0, 0, 0);
    p = '0; launch(16, p, 8'd1, e); wait_done(8'd1, e, "halt-only");
    chk(e == 0, "R8 model halt", e, 0);

    // R4/R5: base ops feed broadcast operands
    mem[32] = ins(8'h02, 0, 0, 0, 18'h123);
    mem[33] = ins(8'h03, 0, 0, 0, 18'h5);
    mem[34] = ins(8'h01, 0, 0, 0, 0);
    mem[35] = ins(8'h85, 0, 0, 1, 0);
    mem[36] = ins(8'hff, 0, 3, 2, 0);
    mem[37] = ins(8'h00, 0, 0, 0, 0);
    p = {32'h44444444, 32'h33333333, 32'h22222222, 32'h11111111};
    launch(32, p, 8'd2, e); wait_done(8'd2, e, "base+ext");

    // R9: undefined base opcode ends the run
    mem[48] = ins(8'h90, 0, 1, 2, 0);
    mem[49] = ins(8'h44, 0, 0, 0, 0);
    mem[50] = ins(8'h91, 0, 0, 0, 0);
    mem[51] = ins(8'h00, 0, 0, 0, 0);
    launch(48, p, 8'd3, e); wait_done(8'd3, 2'd1, "undef");

    // R6: one engine held not ready
    mem[64] = ins(8'ha0, 0, 2, 3, 0);
    mem[65] = ins(8'h00, 0, 0, 0, 0);
    force_low = 4'b0100;
    launch(64, p, 8'd4, e);
    bad = 0;
    repeat (30) begin @(negedge clk); if (cb_valid) bad = 1; end
    chk(!bad, "R6 broadcast held while engine not ready", bad, 0);
    force_low = 0;
    wait_done(8'd4, e, "ready-hold");

    // R10: command written during an active run
    for (int k = 0; k < 8; k++) mem[80 + k] = ins(8'hc0 | 8'(k), 0, k % 4, 0, 0);
    mem[88] = ins(8'h00, 0, 0, 0, 0);
    mem[112] = ins(8'hb3, 0, 0, 1, 0);
    mem[113] = ins(8'h00, 0, 0, 0, 0);
    launch(80, p, 8'd5, e);
    @(negedge clk);
    p[0] = 32'hcafef00d;
    launch(112, p, 8'd6, eb);
    chk(st_seq != 8'd6, "R10 new command not started early", st_seq, 5);
    t = 0;
    do begin @(negedge clk); t++; end while (!(mr_req && mr_addr == 112) && t < 3000);
    chk(st_done && st_seq == 8'd5, "R10 previous status written before pending run", st_seq, 5);
    wait_done(8'd6, eb, "pending");

    // random runs
    seq = 8'd6;
    for (int r = 0; r < 30; r++) begin
      automatic int start = 128 + ($urandom % 100);
      automatic int len = $urandom_range(1, 12);
      gen_prog(start, len, ($urandom % 4) == 0);
      for (int i = 0; i < NP; i++) p[i] = $urandom;
      if (r % 5 == 0) begin
        hw_wr(0, DW'(seq));
        bad = 0;
        repeat (6) begin @(negedge clk); if (mr_req) bad = 1; end
        chk(!bad, "R2 rewrite of same sequence", bad, 0);
      end
      seq = seq + 8'($urandom_range(1, 20));
      launch(16'(start), p, seq, e);
      wait_done(seq, e, "random");
    end
    summary();
  end
endmodule